// File: doc/BRIEF.md
# Speculative Switch Grant Filter

This block sits after the two switch allocators of an input-queued router with `NUM_IN` inputs and `NUM_OUT` outputs. One allocator serves virtual channels (VCs) that already own an output VC. The other serves VCs that bid for the switch while their VC allocation is still in progress. Each cycle the filter merges both sets of per-input grants with any packet-level switch holds. It decides which inputs actually send a flit through the crossbar, and on which output and from which VC.

Non-speculative traffic always wins. A speculative grant is kept only when its input has no non-speculative grant and a static cancellation policy allows it. There are three policies: cancel whenever any non-speculative request exists, cancel when a non-speculative request aimed at the same output, or cancel only when the non-speculative allocator really granted that output. A grant that survives is then checked against the VC's own state. The VC must be in the speculative-grant or active state, its routed output must match the granted output, and the downstream output VC must have room. A speculative win that fails the state or route check is reported as a failed speculation. The block also emits one promotion strobe per VC for every VC still in the speculative-grant state, so that the VC table moves it to active at the end of the cycle.

All outputs are registered, so a decision appears one clock after the inputs that caused it. The policy is the parameter `FILTER_MODE`. Its value 3 is illegal and is reported when the design is elaborated.

Top module: `spec_grant_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, `fwd_vld`, `spec_fail` and `promote` are all zero, whatever the other inputs are.
- R2: When an input has a non-speculative grant and no hold, its forward decision uses that grant's output and VC. Its speculative grant is ignored. The result appears on the outputs one clock edge after the inputs.
- R3: With `FILTER_MODE` 0, a speculative grant is cancelled when any bit of `ns_req_out` is set. With no bit set, it survives.
- R4: With `FILTER_MODE` 1, a speculative grant to output o is cancelled only when `ns_req_out[o]` is set.
- R5: With `FILTER_MODE` 2, a speculative grant to output o is cancelled only when some input holds a valid non-speculative grant to o. A request to o that was not granted does not cancel it.
- R6: A surviving grant forwards only if the selected VC's state is 2 (speculative grant) or 3 (active) and its routed output equals the granted output. State 0 is idle and state 1 is waiting for VC allocation. When a speculative grant fails this check, `spec_fail` is set for that input and nothing is forwarded. A non-speculative grant that fails the check forwards nothing and does not set `spec_fail`.
- R7: A grant that passes R6 but whose selected VC has `vc_room` low forwards nothing and does not set `spec_fail`.
- R8: `promote[i*NUM_VC+v]` is high in the cycle after VC v of input i was in state 2, and low otherwise.
- R9: An input with `hold_vld` high ignores both allocators. It uses `hold_out` and `hold_vc`, subject to the R6 and R7 checks.
- R10: In every cycle, each output is named by at most one forwarding input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ns_gnt_vld | input | NUM_IN | Non-speculative grant valid per input |
| ns_gnt_out | input | NUM_IN*OW | Non-speculative granted output per input |
| ns_gnt_vc | input | NUM_IN*VW | Input VC chosen by the non-speculative allocator |
| sp_gnt_vld | input | NUM_IN | Speculative grant valid per input |
| sp_gnt_out | input | NUM_IN*OW | Speculative granted output per input |
| sp_gnt_vc | input | NUM_IN*VW | Input VC chosen by the speculative allocator |
| ns_req_out | input | NUM_OUT | Some non-speculative request targets this output |
| hold_vld | input | NUM_IN | Input holds a packet-level switch connection |
| hold_out | input | NUM_IN*OW | Held output per input |
| hold_vc | input | NUM_IN*VW | Held input VC per input |
| vc_state | input | NUM_IN*NUM_VC*2 | VC state: 0 idle, 1 waiting, 2 speculative grant, 3 active |
| vc_route | input | NUM_IN*NUM_VC*OW | Output assigned to each VC |
| vc_room | input | NUM_IN*NUM_VC | Downstream output VC of this VC has a free buffer |
| fwd_vld | output | NUM_IN | Input forwards a flit this cycle |
| fwd_out | output | NUM_IN*OW | Output used by the forwarding input |
| fwd_vc | output | NUM_IN*VW | Input VC that sends the flit |
| spec_fail | output | NUM_IN | Speculative grant discarded by the VC check |
| promote | output | NUM_IN*NUM_VC | Move this VC from speculative grant to active |

## Verification
A wrong cancellation policy shows up as a speculative win that appears or disappears at `fwd_vld` one edge after the conflicting request pattern. The bench therefore runs all three policies side by side on the same stimulus, and separates a requested output that was not granted from one that was. A wrong source choice or VC lookup shows up in the same cycle as a wrong `fwd_out`/`fwd_vc`, a missing flit, or two inputs on one output. A confused state or route check shows up as `spec_fail` toggling against `fwd_vld`. The promotion strobes follow the VC states with exactly one cycle of delay.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_WAIT   = 2'd1,
    VS_SPEC   = 2'd2,
    VS_ACTIVE = 2'd3
  } vc_state_e;

  localparam int unsigned POLICY_ANY_REQ = 0;
  localparam int unsigned POLICY_OUT_REQ = 1;
  localparam int unsigned POLICY_OUT_GNT = 2;

  localparam int unsigned STATE_W = 2;

endpackage

// File: rtl/sgf_conflict.sv
module sgf_conflict #(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned OW      = 2,
  parameter int unsigned MODE    = 0
) (
  input  logic [NUM_IN-1:0]    ns_gnt_vld,
  input  logic [NUM_IN*OW-1:0] ns_gnt_out,
  input  logic [NUM_OUT-1:0]   ns_req_out,
  output logic [NUM_OUT-1:0]   kill
);
  import sgf_pkg::*;

  generate
    if (MODE == POLICY_ANY_REQ) begin : g_any
      assign kill = {NUM_OUT{|ns_req_out}};
    end else if (MODE == POLICY_OUT_REQ) begin : g_req
      assign kill = ns_req_out;
    end else if (MODE == POLICY_OUT_GNT) begin : g_gnt
      logic [NUM_OUT-1:0] taken;
      always_comb begin
        taken = '0;
        for (int i = 0; i < NUM_IN; i++) begin
          if (ns_gnt_vld[i]) taken[ns_gnt_out[i*OW +: OW]] = 1'b1;
        end
      end
      assign kill = taken;
    end else begin : g_bad
      assign kill = '1;
      initial $error("sgf_conflict: filter policy %0d is not supported", MODE);
    end
  endgenerate

endmodule

// File: rtl/sgf_lane.sv
module sgf_lane #(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned NUM_VC  = 2,
  parameter int unsigned OW      = 2,
  parameter int unsigned VW      = 1
) (
  input  logic                  hold_vld,
  input  logic [OW-1:0]         hold_out,
  input  logic [VW-1:0]         hold_vc,
  input  logic                  ns_vld,
  input  logic [OW-1:0]         ns_out,
  input  logic [VW-1:0]         ns_vc,
  input  logic                  sp_vld,
  input  logic [OW-1:0]         sp_out,
  input  logic [VW-1:0]         sp_vc,
  input  logic [NUM_OUT-1:0]    kill,
  input  logic [NUM_VC*2-1:0]   st,
  input  logic [NUM_VC*OW-1:0]  route,
  input  logic [NUM_VC-1:0]     room,
  output logic                  go,
  output logic [OW-1:0]         go_out,
  output logic [VW-1:0]         go_vc,
  output logic                  fail
);
  import sgf_pkg::*;

  logic          src_vld;
  logic          src_spec;
  logic [OW-1:0] sel_out;
  logic [VW-1:0] sel_vc;
  vc_state_e     sel_st;
  logic [OW-1:0] sel_route;
  logic          sel_room;
  logic          vc_ok;

  // source priority: hold, then non-speculative, then surviving speculative
  always_comb begin
    src_vld  = 1'b0;
    src_spec = 1'b0;
    sel_out  = '0;
    sel_vc   = '0;
    if (hold_vld) begin
      src_vld = 1'b1;
      sel_out = hold_out;
      sel_vc  = hold_vc;
    end else if (ns_vld) begin
      src_vld = 1'b1;
      sel_out = ns_out;
      sel_vc  = ns_vc;
    end else if (sp_vld && !kill[sp_out]) begin
      src_vld  = 1'b1;
      src_spec = 1'b1;
      sel_out  = sp_out;
      sel_vc   = sp_vc;
    end
  end

  always_comb begin
    sel_st    = vc_state_e'(st[sel_vc*2 +: 2]);
    sel_route = route[sel_vc*OW +: OW];
    sel_room  = room[sel_vc];
    vc_ok     = ((sel_st == VS_SPEC) || (sel_st == VS_ACTIVE)) && (sel_route == sel_out);
  end

  assign go     = src_vld && vc_ok && sel_room;
  assign go_out = sel_out;
  assign go_vc  = sel_vc;
  assign fail   = src_vld && src_spec && !vc_ok;

endmodule

// File: rtl/sgf_promote.sv
module sgf_promote #(
  parameter int unsigned NUM_IN = 4,
  parameter int unsigned NUM_VC = 2
) (
  input  logic [NUM_IN*NUM_VC*2-1:0] st,
  output logic [NUM_IN*NUM_VC-1:0]   spec_mask
);
  import sgf_pkg::*;

  localparam int unsigned NVC = NUM_IN * NUM_VC;

  generate
    for (genvar k = 0; k < NVC; k++) begin : g_vc
      assign spec_mask[k] = (vc_state_e'(st[k*2 +: 2]) == VS_SPEC);
    end
  endgenerate

endmodule

// File: rtl/spec_grant_filter.sv
module spec_grant_filter #(
  parameter int unsigned NUM_IN      = 4,
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned NUM_VC      = 2,
  parameter int unsigned FILTER_MODE = 0,
  localparam int unsigned OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int unsigned VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_IN-1:0]            ns_gnt_vld,
  input  logic [NUM_IN*OW-1:0]         ns_gnt_out,
  input  logic [NUM_IN*VW-1:0]         ns_gnt_vc,
  input  logic [NUM_IN-1:0]            sp_gnt_vld,
  input  logic [NUM_IN*OW-1:0]         sp_gnt_out,
  input  logic [NUM_IN*VW-1:0]         sp_gnt_vc,
  input  logic [NUM_OUT-1:0]           ns_req_out,
  input  logic [NUM_IN-1:0]            hold_vld,
  input  logic [NUM_IN*OW-1:0]         hold_out,
  input  logic [NUM_IN*VW-1:0]         hold_vc,
  input  logic [NUM_IN*NUM_VC*2-1:0]   vc_state,
  input  logic [NUM_IN*NUM_VC*OW-1:0]  vc_route,
  input  logic [NUM_IN*NUM_VC-1:0]     vc_room,
  output logic [NUM_IN-1:0]            fwd_vld,
  output logic [NUM_IN*OW-1:0]         fwd_out,
  output logic [NUM_IN*VW-1:0]         fwd_vc,
  output logic [NUM_IN-1:0]            spec_fail,
  output logic [NUM_IN*NUM_VC-1:0]     promote
);
  import sgf_pkg::*;

  localparam int unsigned NVC = NUM_IN * NUM_VC;

  logic [NUM_OUT-1:0]   kill;
  logic [NUM_IN-1:0]    go_n;
  logic [NUM_IN*OW-1:0] go_out_n;
  logic [NUM_IN*VW-1:0] go_vc_n;
  logic [NUM_IN-1:0]    fail_n;
  logic [NVC-1:0]       spec_mask;

  sgf_conflict #(
    .NUM_IN (NUM_IN),
    .NUM_OUT(NUM_OUT),
    .OW     (OW),
    .MODE   (FILTER_MODE)
  ) u_conflict (
    .ns_gnt_vld(ns_gnt_vld),
    .ns_gnt_out(ns_gnt_out),
    .ns_req_out(ns_req_out),
    .kill      (kill)
  );

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
      sgf_lane #(
        .NUM_OUT(NUM_OUT),
        .NUM_VC (NUM_VC),
        .OW     (OW),
        .VW     (VW)
      ) u_lane (
        .hold_vld(hold_vld[i]),
        .hold_out(hold_out[i*OW +: OW]),
        .hold_vc (hold_vc[i*VW +: VW]),
        .ns_vld  (ns_gnt_vld[i]),
        .ns_out  (ns_gnt_out[i*OW +: OW]),
        .ns_vc   (ns_gnt_vc[i*VW +: VW]),
        .sp_vld  (sp_gnt_vld[i]),
        .sp_out  (sp_gnt_out[i*OW +: OW]),
        .sp_vc   (sp_gnt_vc[i*VW +: VW]),
        .kill    (kill),
        .st      (vc_state[i*NUM_VC*2 +: NUM_VC*2]),
        .route   (vc_route[i*NUM_VC*OW +: NUM_VC*OW]),
        .room    (vc_room[i*NUM_VC +: NUM_VC]),
        .go      (go_n[i]),
        .go_out  (go_out_n[i*OW +: OW]),
        .go_vc   (go_vc_n[i*VW +: VW]),
        .fail    (fail_n[i])
      );
    end
  endgenerate

  sgf_promote #(
    .NUM_IN(NUM_IN),
    .NUM_VC(NUM_VC)
  ) u_promote (
    .st       (vc_state),
    .spec_mask(spec_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_vld   <= '0;
      fwd_out   <= '0;
      fwd_vc    <= '0;
      spec_fail <= '0;
      promote   <= '0;
    end else begin
      fwd_vld   <= go_n;
      fwd_out   <= go_out_n;
      fwd_vc    <= go_vc_n;
      spec_fail <= fail_n;
      promote   <= spec_mask;
    end
  end

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (fwd_vld == '0 && spec_fail == '0 && promote == '0));

  p_fail_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (fwd_vld & spec_fail) == '0);

  p_promote_track_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (promote == $past(spec_mask)));

  logic [NUM_IN-1:0] out_hit [NUM_OUT];
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        out_hit[o][i] = fwd_vld[i] && (fwd_out[i*OW +: OW] == OW'(o));
      end
    end
  end

  generate
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_chk
      p_one_per_out_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_hit[o]));
    end
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in_chk
      p_hold_path_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold_vld[i]) && fwd_vld[i]) |->
          (fwd_out[i*OW +: OW] == $past(hold_out[i*OW +: OW]) &&
           fwd_vc[i*VW +: VW] == $past(hold_vc[i*VW +: VW])));
      p_ns_first_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hold_vld[i]) && $past(ns_gnt_vld[i])) |->
          (!spec_fail[i] && (!fwd_vld[i] ||
           fwd_out[i*OW +: OW] == $past(ns_gnt_out[i*OW +: OW]))));
    end
  endgenerate

endmodule

// File: tb/test_spec_grant_filter.sv
`timescale 1ns/1ps
module test_spec_grant_filter;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int V  = 2;
  localparam int OW = 2;
  localparam int VW = 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_SPEC = 2'd2, S_ACT = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0]      ns_gnt_vld, sp_gnt_vld, hold_vld;
  logic [N*OW-1:0]   ns_gnt_out, sp_gnt_out, hold_out;
  logic [N*VW-1:0]   ns_gnt_vc, sp_gnt_vc, hold_vc;
  logic [M-1:0]      ns_req_out;
  logic [N*V*2-1:0]  vc_state;
  logic [N*V*OW-1:0] vc_route;
  logic [N*V-1:0]    vc_room;

  logic [N-1:0]    fv_m [3];
  logic [N*OW-1:0] fo_m [3];
  logic [N*VW-1:0] fc_m [3];
  logic [N-1:0]    sf_m [3];
  logic [N*V-1:0]  pr_m [3];

  spec_grant_filter #(.NUM_IN(N), .NUM_OUT(M), .NUM_VC(V), .FILTER_MODE(0)) i_spec_grant_filter (
    .clk(clk), .rst(rst),
    .ns_gnt_vld(ns_gnt_vld), .ns_gnt_out(ns_gnt_out), .ns_gnt_vc(ns_gnt_vc),
    .sp_gnt_vld(sp_gnt_vld), .sp_gnt_out(sp_gnt_out), .sp_gnt_vc(sp_gnt_vc),
    .ns_req_out(ns_req_out), .hold_vld(hold_vld), .hold_out(hold_out), .hold_vc(hold_vc),
    .vc_state(vc_state), .vc_route(vc_route), .vc_room(vc_room),
    .fwd_vld(fv_m[0]), .fwd_out(fo_m[0]), .fwd_vc(fc_m[0]), .spec_fail(sf_m[0]), .promote(pr_m[0]));

  spec_grant_filter #(.NUM_IN(N), .NUM_OUT(M), .NUM_VC(V), .FILTER_MODE(1)) i_spec_grant_filter_m1 (
    .clk(clk), .rst(rst),
    .ns_gnt_vld(ns_gnt_vld), .ns_gnt_out(ns_gnt_out), .ns_gnt_vc(ns_gnt_vc),
    .sp_gnt_vld(sp_gnt_vld), .sp_gnt_out(sp_gnt_out), .sp_gnt_vc(sp_gnt_vc),
    .ns_req_out(ns_req_out), .hold_vld(hold_vld), .hold_out(hold_out), .hold_vc(hold_vc),
    .vc_state(vc_state), .vc_route(vc_route), .vc_room(vc_room),
    .fwd_vld(fv_m[1]), .fwd_out(fo_m[1]), .fwd_vc(fc_m[1]), .spec_fail(sf_m[1]), .promote(pr_m[1]));

  spec_grant_filter #(.NUM_IN(N), .NUM_OUT(M), .NUM_VC(V), .FILTER_MODE(2)) i_spec_grant_filter_m2 (
    .clk(clk), .rst(rst),
    .ns_gnt_vld(ns_gnt_vld), .ns_gnt_out(ns_gnt_out), .ns_gnt_vc(ns_gnt_vc),
    .sp_gnt_vld(sp_gnt_vld), .sp_gnt_out(sp_gnt_out), .sp_gnt_vc(sp_gnt_vc),
    .ns_req_out(ns_req_out), .hold_vld(hold_vld), .hold_out(hold_out), .hold_vc(hold_vc),
    .vc_state(vc_state), .vc_route(vc_route), .vc_room(vc_room),
    .fwd_vld(fv_m[2]), .fwd_out(fo_m[2]), .fwd_vc(fc_m[2]), .spec_fail(sf_m[2]), .promote(pr_m[2]));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic clear_in();
    ns_gnt_vld = '0; ns_gnt_out = '0; ns_gnt_vc = '0;
    sp_gnt_vld = '0; sp_gnt_out = '0; sp_gnt_vc = '0;
    hold_vld = '0; hold_out = '0; hold_vc = '0;
    ns_req_out = '0; vc_state = '0; vc_route = '0; vc_room = '0;
  endtask

  task automatic set_vc(int i, int v, logic [1:0] st, int rt, bit rm);
    vc_state[(i*V+v)*2 +: 2]   = st;
    vc_route[(i*V+v)*OW +: OW] = rt[OW-1:0];
    vc_room[i*V+v]             = rm;
  endtask

  task automatic give_ns(int i, int o, int v);
    ns_gnt_vld[i] = 1'b1; ns_gnt_out[i*OW +: OW] = o[OW-1:0]; ns_gnt_vc[i*VW +: VW] = v[VW-1:0];
  endtask

  task automatic give_sp(int i, int o, int v);
    sp_gnt_vld[i] = 1'b1; sp_gnt_out[i*OW +: OW] = o[OW-1:0]; sp_gnt_vc[i*VW +: VW] = v[VW-1:0];
  endtask

  task automatic give_hold(int i, int o, int v);
    hold_vld[i] = 1'b1; hold_out[i*OW +: OW] = o[OW-1:0]; hold_vc[i*VW +: VW] = v[VW-1:0];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_lane(int m, int i, bit ev, int eo, int evc, bit ef, string tag);
    bit av, af;
    int ao, ac;
    av = fv_m[m][i]; af = sf_m[m][i];
    ao = int'(fo_m[m][i*OW +: OW]); ac = int'(fc_m[m][i*VW +: VW]);
    checks++;
    if (av !== ev || af !== ef || (ev && (ao != eo || ac != evc))) begin
      errors++;
      $display("FAIL %s mode%0d in%0d: got vld=%0d out=%0d vc=%0d fail=%0d, want vld=%0d out=%0d vc=%0d fail=%0d",
               tag, m, i, av, ao, ac, af, ev, eo, evc, ef);
    end
  endtask

  task automatic chk_all(int i, bit ev, int eo, int evc, bit ef, string tag);
    for (int m = 0; m < 3; m++) chk_lane(m, i, ev, eo, evc, ef, tag);
  endtask

  task automatic chk_prom(logic [N*V-1:0] exp_p, string tag);
    for (int m = 0; m < 3; m++) begin
      checks++;
      if (pr_m[m] !== exp_p) begin
        errors++;
        $display("FAIL %s mode%0d promote: got %b want %b", tag, m, pr_m[m], exp_p);
      end
    end
  endtask

  // R10: every output carries at most one forwarding input
  task automatic chk_unique(string tag);
    for (int m = 0; m < 3; m++) begin
      for (int o = 0; o < M; o++) begin
        int cnt = 0;
        for (int i = 0; i < N; i++)
          if (fv_m[m][i] && int'(fo_m[m][i*OW +: OW]) == o) cnt++;
        checks++;
        if (cnt > 1) begin
          errors++;
          $display("FAIL %s mode%0d out%0d: got %0d users want at most 1", tag, m, o, cnt);
        end
      end
    end
  endtask

  task automatic t_reset();
    clear_in();
    set_vc(0, 0, S_SPEC, 1, 1);
    give_sp(0, 1, 0);
    rst = 1'b1;
    step(); step();
    for (int i = 0; i < N; i++) chk_all(i, 0, 0, 0, 0, "R1 reset");
    chk_prom('0, "R1 reset");
    rst = 1'b0;
  endtask

  task automatic t_priority();
    clear_in();
    set_vc(0, 0, S_ACT, 1, 1);
    set_vc(0, 1, S_SPEC, 2, 1);
    give_ns(0, 1, 0);
    give_sp(0, 2, 1);
    ns_req_out[1] = 1'b1;
    step();
    chk_all(0, 1, 1, 0, 0, "R2 ns wins");
    chk_prom(8'b0000_0010, "R8 promote");
  endtask

  task automatic t_policies();
    clear_in();
    set_vc(0, 0, S_ACT, 1, 1);
    give_ns(0, 1, 0);
    ns_req_out[1] = 1'b1;
    set_vc(1, 0, S_SPEC, 3, 1);
    give_sp(1, 3, 0);
    step();
    chk_all(0, 1, 1, 0, 0, "R2 ns lane");
    chk_lane(0, 1, 0, 0, 0, 0, "R3 any request cancels");
    chk_lane(1, 1, 1, 3, 0, 0, "R4 other output kept");
    chk_lane(2, 1, 1, 3, 0, 0, "R5 ungranted kept");
    ns_req_out[3] = 1'b1;
    step();
    chk_lane(0, 1, 0, 0, 0, 0, "R3 cancel");
    chk_lane(1, 1, 0, 0, 0, 0, "R4 same output cancel");
    chk_lane(2, 1, 1, 3, 0, 0, "R5 request without grant");
    set_vc(2, 1, S_ACT, 3, 1);
    give_ns(2, 3, 1);
    step();
    chk_all(1, 0, 0, 0, 0, "R5 granted output cancels");
    chk_all(2, 1, 3, 1, 0, "R2 ns lane2");
    chk_unique("R10 unique");
    clear_in();
    set_vc(1, 0, S_SPEC, 3, 1);
    give_sp(1, 3, 0);
    step();
    chk_all(1, 1, 3, 0, 0, "R3 no requests keeps");
  endtask

  task automatic t_vc_check();
    clear_in();
    set_vc(1, 1, S_WAIT, 2, 1);
    give_sp(1, 2, 1);
    step();
    chk_all(1, 0, 0, 0, 1, "R6 waiting state");
    set_vc(1, 1, S_SPEC, 0, 1);
    step();
    chk_all(1, 0, 0, 0, 1, "R6 route mismatch");
    set_vc(1, 1, S_ACT, 2, 1);
    step();
    chk_all(1, 1, 2, 1, 0, "R6 good spec");
    clear_in();
    set_vc(3, 0, S_IDLE, 1, 1);
    give_ns(3, 1, 0);
    ns_req_out[1] = 1'b1;
    step();
    chk_all(3, 0, 0, 0, 0, "R6 ns bad state");
  endtask

  task automatic t_room();
    clear_in();
    set_vc(3, 1, S_SPEC, 0, 0);
    give_sp(3, 0, 1);
    step();
    chk_all(3, 0, 0, 0, 0, "R7 spec no room");
    set_vc(3, 1, S_ACT, 0, 0);
    give_ns(3, 0, 1);
    ns_req_out[0] = 1'b1;
    step();
    chk_all(3, 0, 0, 0, 0, "R7 ns no room");
  endtask

  task automatic t_hold();
    clear_in();
    set_vc(2, 1, S_ACT, 0, 1);
    set_vc(2, 0, S_ACT, 1, 1);
    give_hold(2, 0, 1);
    give_ns(2, 1, 0);
    ns_req_out[1] = 1'b1;
    give_sp(2, 3, 0);
    step();
    chk_all(2, 1, 0, 1, 0, "R9 hold bypass");
    set_vc(2, 1, S_ACT, 0, 0);
    step();
    chk_all(2, 0, 0, 0, 0, "R9 hold no room");
  endtask

  task automatic t_promote();
    clear_in();
    set_vc(3, 1, S_SPEC, 0, 1);
    set_vc(1, 0, S_SPEC, 2, 0);
    set_vc(2, 0, S_ACT, 1, 1);
    step();
    chk_prom(8'b1000_0100, "R8 promote set");
    clear_in();
    step();
    chk_prom('0, "R8 promote clear");
  endtask

  initial begin
    clear_in();
    @(negedge clk);
    t_reset();
    t_priority();
    t_policies();
    t_vc_check();
    t_room();
    t_hold();
    t_promote();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule